// File: doc/BRIEF.md
# Power-Up Configuration Delay Controller

This block decides when a device may start accepting configuration data after power-up. From reset it pulls the shared open-drain INIT line low while the internal configuration memory is being cleared. Once the clear has finished it lets go of the line and waits. An external agent that keeps INIT low can hold off configuration for as long as it likes.

When the synchronized INIT level is seen high, the block latches the mode pins. It then keeps the configuration logic in reset for a fixed number of slow-oscillator ticks. A master-mode device then waits a further programmable number of ticks, so that any daisy-chained slaves have seen INIT high. After that the configuration-enable output rises and stays high until reset. The length counter downstream may begin counting at that point.

If INIT drops low again before configuration is enabled, the count is abandoned. The block returns to waiting, and the mode is captured afresh at the next release.

Top module: `cfg_dly_ctrl`

## Requirements
- R1: After reset, init_pd_o is 1, cfg_en_o is 0 and mode_o is all zeros.
- R2: init_pd_o stays 1 until clear_done_i is 1 at a clock edge. It is 0 from that edge onward, and it stays 0 until the next reset, whatever clear_done_i or INIT do.
- R3: While the INIT line reads low after the clear, the block waits for as long as the line stays low. During the wait cfg_en_o stays 0, mode_o is not updated, and osc_tick_i pulses have no effect.
- R4: INIT passes through a two-flop synchronizer. mode_o takes the value of mode_i at the third clock edge after the line goes high. Later changes of mode_i have no effect on mode_o.
- R5: Slave mode is a captured mode with bit 0 equal to 0. In slave mode, cfg_en_o rises at the clock edge of the RST_TICKS-th osc_tick_i pulse (default 2), counting only pulses at or after the fourth edge after INIT goes high.
- R6: Master mode is a captured mode with bit 0 equal to 1. In master mode, cfg_en_o rises at the edge of the (RST_TICKS+MASTER_TICKS)-th counted pulse. With the defaults this is the 66th pulse.
- R7: If INIT reads low again before cfg_en_o rises, the tick count is discarded and the block returns to waiting. After the next release it needs the full tick count again, and it recaptures mode_i.
- R8: Once cfg_en_o is 1 it stays 1 until reset, and mode_o holds its value, whatever happens on INIT, the ticks or mode_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_pin_i | input | 1 | Sampled level of the open-drain INIT line (asynchronous) |
| clear_done_i | input | 1 | Configuration memory clear has finished |
| mode_i | input | MODE_W | Mode pins |
| osc_tick_i | input | 1 | One-cycle pulse per slow-oscillator period |
| init_pd_o | output | 1 | Enable for the INIT pull-down driver |
| mode_o | output | MODE_W | Mode latched at INIT release |
| cfg_en_o | output | 1 | Configuration may start |

## Verification
The assertions take for granted three things about the inputs. osc_tick_i is a single-cycle pulse in the clock domain. mode_i is steady around the edge on which INIT is first seen high. The INIT line is the wired-AND of this block's pull-down and any external holder. The bench models the line in exactly that way. It changes every input on the falling clock edge and issues ticks as isolated one-cycle pulses. It changes mode_i only after the capture edge has passed.

// File: rtl/cfg_dly_pkg.sv
package cfg_dly_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR = 3'd0,
    ST_WAIT  = 3'd1,
    ST_HOLD  = 3'd2,
    ST_MDLY  = 3'd3,
    ST_CFG   = 3'd4
  } cfg_state_e;
endpackage

// File: rtl/cfg_dly_sync.sv
module cfg_dly_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_dly_tick_cnt.sv
module cfg_dly_tick_cnt #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] last;

  assign last   = limit_i - {{(W-1){1'b0}}, 1'b1};
  assign done_o = en_i && tick_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || done_o) cnt_q <= '0;
    else if (en_i && tick_i)  cnt_q <= cnt_q + {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/cfg_dly_fsm.sv
module cfg_dly_fsm
  import cfg_dly_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_done_i,
  input  logic       init_s_i,
  input  logic       master_i,
  input  logic       cnt_done_i,
  output cfg_state_e state_o,
  output logic       capture_o
);
  cfg_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    capture_o = 1'b0;
    unique case (state_q)
      ST_CLEAR: if (clear_done_i) state_d = ST_WAIT;
      ST_WAIT: if (init_s_i) begin
        state_d   = ST_HOLD;
        capture_o = 1'b1;
      end
      ST_HOLD: begin
        if (!init_s_i)       state_d = ST_WAIT;
        else if (cnt_done_i) state_d = master_i ? ST_MDLY : ST_CFG;
      end
      ST_MDLY: begin
        if (!init_s_i)       state_d = ST_WAIT;
        else if (cnt_done_i) state_d = ST_CFG;
      end
      ST_CFG:  state_d = ST_CFG;
      default: state_d = ST_CLEAR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_CLEAR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/cfg_dly_ctrl.sv
module cfg_dly_ctrl
  import cfg_dly_pkg::*;
#(
  parameter int MODE_W       = 3,
  parameter int RST_TICKS    = 2,
  parameter int MASTER_TICKS = 64,
  parameter int SYNC_STAGES  = 2,
  parameter int MASTER_BIT   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_pin_i,
  input  logic              clear_done_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              osc_tick_i,
  output logic              init_pd_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              cfg_en_o
);
  localparam int MAX_TICKS = (RST_TICKS > MASTER_TICKS) ? RST_TICKS : MASTER_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  cfg_state_e        state;
  logic              init_s;
  logic              capture;
  logic              cnt_done;
  logic              counting;
  logic [CNT_W-1:0]  limit;
  logic [MODE_W-1:0] mode_q;

  cfg_dly_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (init_pin_i),
    .q_o   (init_s)
  );

  assign counting = (state == ST_HOLD) || (state == ST_MDLY);
  assign limit    = (state == ST_MDLY) ? CNT_W'(MASTER_TICKS) : CNT_W'(RST_TICKS);

  cfg_dly_tick_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!counting || !init_s),
    .en_i   (counting && init_s),
    .tick_i (osc_tick_i),
    .limit_i(limit),
    .done_o (cnt_done)
  );

  cfg_dly_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_done_i(clear_done_i),
    .init_s_i    (init_s),
    .master_i    (mode_q[MASTER_BIT]),
    .cnt_done_i  (cnt_done),
    .state_o     (state),
    .capture_o   (capture)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (capture) mode_q <= mode_i;
  end

  assign init_pd_o = (state == ST_CLEAR);
  assign mode_o    = mode_q;
  assign cfg_en_o  = (state == ST_CFG);
endmodule

// File: rtl/cfg_dly_ctrl_chk.sv
module cfg_dly_ctrl_chk #(
  parameter int MODE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_done_i,
  input logic              osc_tick_i,
  input logic              init_s_i,
  input logic              init_pd_o,
  input logic [MODE_W-1:0] mode_o,
  input logic              cfg_en_o
);
  p_pd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_pd_o && !clear_done_i |=> init_pd_o);

  p_pd_no_reassert_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_pd_o |=> !init_pd_o);

  p_cfg_after_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_o |-> !init_pd_o);

  p_no_cfg_while_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_s_i && !cfg_en_o |=> !cfg_en_o);

  p_cfg_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_en_o) |-> $past(osc_tick_i));

  p_cfg_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_o |=> cfg_en_o);

  p_mode_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_o |=> $stable(mode_o));
endmodule

bind cfg_dly_ctrl cfg_dly_ctrl_chk #(.MODE_W(MODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_done_i(clear_done_i),
  .osc_tick_i  (osc_tick_i),
  .init_s_i    (init_s),
  .init_pd_o   (init_pd_o),
  .mode_o      (mode_o),
  .cfg_en_o    (cfg_en_o)
);

// File: tb/cfg_dly_ctrl_tb.sv
module cfg_dly_ctrl_tb;
  localparam int MODE_W = 3;
  localparam int RST_T  = 2;
  localparam int MST_T  = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ext_hold = 1'b1;
  logic              clear_done = 1'b0;
  logic [MODE_W-1:0] mode = '0;
  logic              tick = 1'b0;
  logic              init_line;
  logic              init_pd;
  logic [MODE_W-1:0] mode_o;
  logic              cfg_en;
  int                n_run = 0;
  int                n_fail = 0;
  bit                done = 1'b0;

  always #4 clk = ~clk;

  // wired-AND open-drain line
  assign init_line = !(init_pd || ext_hold);

  cfg_dly_ctrl #(.MODE_W(MODE_W), .RST_TICKS(RST_T), .MASTER_TICKS(MST_T)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .init_pin_i  (init_line),
    .clear_done_i(clear_done),
    .mode_i      (mode),
    .osc_tick_i  (tick),
    .init_pd_o   (init_pd),
    .mode_o      (mode_o),
    .cfg_en_o    (cfg_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ext_hold = 1'b1; clear_done = 1'b0; tick = 1'b0; mode = '0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic to_wait();
    do_reset();
    clear_done = 1'b1;
    cyc(1);
    clear_done = 1'b0;
  endtask

  task automatic release_init(input logic [MODE_W-1:0] m);
    mode = m;
    ext_hold = 1'b0;
    cyc(3);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pd", init_pd, 1);
    chk("R1 cfg_en", cfg_en, 0);
    chk("R1 mode", mode_o, 0);
  endtask

  task automatic t_clear();
    do_reset();
    ext_hold = 1'b0;
    cyc(10);
    chk("R2 pd held during clear", init_pd, 1);
    clear_done = 1'b1;
    cyc(1);
    chk("R2 pd released", init_pd, 0);
    clear_done = 1'b0;
    ext_hold = 1'b1;
    cyc(5);
    chk("R2 pd stays released", init_pd, 0);
  endtask

  task automatic t_hold_low();
    to_wait();
    mode = 3'b111;
    for (int i = 0; i < 20; i++) pulse_tick();
    cyc(50);
    chk("R3 cfg_en while held", cfg_en, 0);
    chk("R3 mode not captured", mode_o, 0);
  endtask

  task automatic t_slave();
    to_wait();
    release_init(3'b010);
    chk("R4 mode captured", mode_o, 3'b010);
    mode = 3'b101;
    pulse_tick();
    chk("R5 cfg_en after 1 tick", cfg_en, 0);
    pulse_tick();
    chk("R5 cfg_en after 2 ticks", cfg_en, 1);
    chk("R4 mode unchanged", mode_o, 3'b010);
  endtask

  task automatic t_master();
    int early = 0;
    to_wait();
    release_init(3'b001);
    for (int i = 0; i < RST_T + MST_T - 1; i++) begin
      pulse_tick();
      if (cfg_en) early++;
    end
    chk("R6 no early cfg_en", early, 0);
    pulse_tick();
    chk("R6 cfg_en after full delay", cfg_en, 1);
  endtask

  task automatic t_restart();
    to_wait();
    release_init(3'b010);
    pulse_tick();
    ext_hold = 1'b1;
    cyc(3);
    pulse_tick();
    pulse_tick();
    chk("R7 no cfg_en after drop", cfg_en, 0);
    release_init(3'b100);
    chk("R7 mode recaptured", mode_o, 3'b100);
    pulse_tick();
    chk("R7 count restarted", cfg_en, 0);
    pulse_tick();
    chk("R7 cfg_en after full count", cfg_en, 1);
  endtask

  task automatic t_sticky();
    to_wait();
    release_init(3'b110);
    pulse_tick();
    pulse_tick();
    ext_hold = 1'b1;
    mode = 3'b001;
    for (int i = 0; i < 5; i++) pulse_tick();
    cyc(10);
    chk("R8 cfg_en sticky", cfg_en, 1);
    chk("R8 mode frozen", mode_o, 3'b110);
    chk("R8 pd stays off", init_pd, 0);
  endtask

  initial begin
    t_reset();
    t_clear();
    t_hold_low();
    t_slave();
    t_master();
    t_restart();
    t_sticky();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule